// File: doc/BRIEF.md
# Four-Master Shared Bus Arbiter

This block decides which of several masters may drive a shared system bus. Each master raises a request line and receives a grant line. A single busy output shows that the bus is owned. Only one master holds the grant at a time. A grant is issued only while the bus is idle, and it stays with its owner for as long as that owner keeps its request raised.

A two-bit mode input selects one of three selection policies:
- **Serial.** A chain of cells passes a priority token from position 0 upward.
- **Parallel.** A priority encoder feeds a binary decoder.
- **Rotating.** The chain starts just after the master that most recently held the bus.

All three policies feed one set of registered grant flip-flops. The mode is sampled only when a new grant is decided, so it is meant to be static while the bus is busy.

Top module: `busgrant_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every grant bit and busy are 0.
- R2: At most one grant bit is 1 in any cycle.
- R3: Busy is 1 exactly in the cycles in which one grant bit is 1.
- R4: A new grant appears only after a clock edge at which busy was 0 and at least one request was 1. The granted master is one whose request was 1 at that edge. While the owner keeps its request at 1, the grant does not change.
- R5: When the owner's request is 0 at a clock edge, grant and busy become 0 after that edge. No new grant is issued before the following edge, even if other requests were present at the release edge.
- R6: With mode 0 (serial chain), the requesting master with the lowest index wins.
- R7: With mode 1 (encoder and decoder), the requesting master with the lowest index wins.
- R8: With mode 2 (rotating chain), the winner is the first requesting master found by searching upward from the index after the last owner, wrapping from index 3 to index 0.
- R9: Reset sets the last owner to index 3, so the first rotating decision favours master 0.
- R10: The last owner is updated on every grant, whatever the mode that produced it.
- R11: Mode 3 selects by the same rule as mode 0.
- R12: Requests from masters other than the owner have no effect on grant or busy while the bus is busy.
- R13: A mode change made while the bus is busy takes effect at the first decision after the owner releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Policy: 0 serial, 1 parallel, 2 rotating, 3 serial |
| req | input | N | One request line per master |
| grant | output | N | Registered one-hot grant, or all zero |
| busy | output | 1 | Registered bus-owned indication |

## Verification
Two events can fall on the same clock edge: an owner's release and other masters' requests. The bench provokes this by dropping the owner's request while other requests stay high. It then expects an idle cycle before the next grant. A mode change during ownership also collides with the release, because the bench switches mode while busy and then releases. In that case the winner must follow the new mode and the last owner recorded under the old one. A behavioural model with its own search loop is compared against grant and busy on every clock, across directed sequences and a long random stream of requests and modes.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    MODE_SERIAL   = 2'd0,
    MODE_PARALLEL = 2'd1,
    MODE_ROTATE   = 2'd2,
    MODE_SPARE    = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/daisy_chain.sv
// Priority-token chain: position 0 receives a tied-high token.
module daisy_chain #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] tok;

  assign tok[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_cell
    // A requesting cell keeps the token; an idle cell passes it on.
    assign gnt[i]   = tok[i] & req[i];
    assign tok[i+1] = tok[i] & ~req[i];
  end
endmodule

// File: rtl/prio_encdec.sv
// Priority encoder (lowest index wins) followed by a binary decoder.
module prio_encdec #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] ack
);
  logic [IDX_W-1:0] code;
  logic             valid;

  always_comb begin
    code  = '0;
    valid = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        code  = IDX_W'(i);
        valid = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign ack[i] = valid && (code == IDX_W'(i));
  end
endmodule

// File: rtl/rotate_chain.sv
// Rotating chain: the requests are rotated so the slot after the last
// owner sits at the head of a plain token chain, then the result is
// rotated back. This avoids a combinational ring.
module rotate_chain #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic [N-1:0]     gnt
);
  logic [N-1:0] rot_req;
  logic [N-1:0] rot_gnt;
  int           head;

  always_comb begin
    head = (int'(last) >= N - 1) ? 0 : int'(last) + 1;
    for (int k = 0; k < N; k++) begin
      rot_req[k] = req[(head + k) % N];
    end
  end

  daisy_chain #(.N(N)) u_chain (
    .req (rot_req),
    .gnt (rot_gnt)
  );

  always_comb begin
    gnt = '0;
    for (int k = 0; k < N; k++) begin
      gnt[(head + k) % N] = rot_gnt[k];
    end
  end
endmodule

// File: rtl/busgrant_arbiter.sv
module busgrant_arbiter
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         busy
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] last_q;
  logic [N-1:0]     ser_g, par_g, rot_g, win_g;
  logic [IDX_W-1:0] win_idx;
  logic             owner_holds;

  daisy_chain #(.N(N)) u_serial (
    .req (req),
    .gnt (ser_g)
  );

  prio_encdec #(.N(N), .IDX_W(IDX_W)) u_parallel (
    .req (req),
    .ack (par_g)
  );

  rotate_chain #(.N(N), .IDX_W(IDX_W)) u_rotate (
    .req  (req),
    .last (last_q),
    .gnt  (rot_g)
  );

  always_comb begin
    case (arb_mode_e'(mode))
      MODE_PARALLEL: win_g = par_g;
      MODE_ROTATE:   win_g = rot_g;
      default:       win_g = ser_g;
    endcase
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win_g[i]) win_idx = IDX_W'(i);
    end
  end

  assign owner_holds = |(grant & req);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant  <= '0;
      busy   <= 1'b0;
      last_q <= IDX_W'(N - 1);
    end else if (busy) begin
      if (!owner_holds) begin
        grant <= '0;
        busy  <= 1'b0;
      end
    end else if (|win_g) begin
      grant  <= win_g;
      busy   <= 1'b1;
      last_q <= win_idx;
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (grant != '0));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && owner_holds) |=> $stable(grant));

  // R4
  grant_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy) |=> ((grant & $past(req)) == grant));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !owner_holds) |=> (!busy && grant == '0));

  // R4
  idle_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req != '0) |=> busy);
endmodule

// File: tb/busgrant_arbiter_test.sv
module busgrant_arbiter_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'd0;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant;
  logic         busy;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] m_g = '0;
  logic         m_b = 1'b0;
  int           m_last = N - 1;
  string        m_tag = "R1";

  always #2 clk = ~clk;

  busgrant_arbiter #(.N(N)) uut (
    .clk(clk), .rst(rst), .mode(mode), .req(req),
    .grant(grant), .busy(busy)
  );

  function automatic int choose(logic [N-1:0] r, logic [1:0] md, int lst);
    int start;
    start = (md == 2'd2) ? (lst + 1) % N : 0;
    for (int k = 0; k < N; k++) begin
      if (r[(start + k) % N]) return (start + k) % N;
    end
    return -1;
  endfunction

  task automatic model_edge();
    int w;
    if (rst) begin
      m_g = '0; m_b = 1'b0; m_last = N - 1; m_tag = "R1";
    end else if (m_b) begin
      if ((m_g & req) == '0) begin
        m_g = '0; m_b = 1'b0; m_tag = "R5";
      end else m_tag = "R12";
    end else begin
      w = choose(req, mode, m_last);
      if (w >= 0) begin
        m_g = '0; m_g[w] = 1'b1; m_b = 1'b1; m_last = w;
        m_tag = (mode == 2'd1) ? "R7" : (mode == 2'd2) ? "R8" :
                (mode == 2'd3) ? "R11" : "R6";
      end else m_tag = "R4";
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (grant !== m_g || busy !== m_b) begin
      errors++;
      $display("FAIL %s model: grant=%b busy=%b expected grant=%b busy=%b",
               m_tag, grant, busy, m_g, m_b);
    end
  endtask

  task automatic expect_now(string tag, logic [N-1:0] eg, logic eb);
    checks++;
    if (grant !== eg || busy !== eb) begin
      errors++;
      $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
               tag, grant, busy, eg, eb);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0;
    tick(); tick();
    expect_now("R1", 4'b0000, 1'b0);
    rst = 1'b0;
    tick();
    expect_now("R1", 4'b0000, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // Serial mode, with a bystander request and a release collision.
    mode = 2'd0; req = 4'b1010; tick();
    expect_now("R6", 4'b0010, 1'b1);
    req = 4'b1011; tick();
    expect_now("R12", 4'b0010, 1'b1);
    req = 4'b1001; tick();
    expect_now("R5", 4'b0000, 1'b0);
    tick();
    expect_now("R6", 4'b0001, 1'b1);
    req = 4'b0000; tick(); tick();

    // Parallel mode.
    mode = 2'd1; req = 4'b1100; tick();
    expect_now("R7", 4'b0100, 1'b1);
    req = 4'b1000; tick(); tick();
    expect_now("R7", 4'b1000, 1'b1);
    req = 4'b0000; tick(); tick();

    // Rotating mode after a fresh reset.
    do_reset();
    mode = 2'd2; req = 4'b1111; tick();
    expect_now("R9", 4'b0001, 1'b1);
    req = 4'b1110; tick(); tick();
    expect_now("R8", 4'b0010, 1'b1);
    req = 4'b1101; tick(); tick();
    expect_now("R8", 4'b0100, 1'b1);
    req = 4'b1011; tick(); tick();
    expect_now("R8", 4'b1000, 1'b1);
    req = 4'b0111; tick(); tick();
    expect_now("R8", 4'b0001, 1'b1);
    req = 4'b0000; tick(); tick();

    // Last owner set by a serial grant steers the rotation.
    mode = 2'd0; req = 4'b0100; tick();
    expect_now("R10", 4'b0100, 1'b1);
    req = 4'b0000; tick();
    mode = 2'd2; req = 4'b1111; tick();
    expect_now("R10", 4'b1000, 1'b1);
    req = 4'b0000; tick(); tick();

    // Mode change while busy.
    mode = 2'd0; req = 4'b0010; tick();
    expect_now("R13", 4'b0010, 1'b1);
    mode = 2'd2; req = 4'b1011; tick();
    expect_now("R13", 4'b0010, 1'b1);
    req = 4'b1001; tick();
    tick();
    expect_now("R13", 4'b1000, 1'b1);
    req = 4'b0000; tick(); tick();

    // Spare mode code follows the serial rule (last owner is 3 here).
    mode = 2'd2; req = 4'b0010; tick();
    req = 4'b0000; tick();
    mode = 2'd3; req = 4'b0110; tick();
    expect_now("R11", 4'b0010, 1'b1);
    req = 4'b0000; tick(); tick();

    // Random stream compared against the model every clock.
    for (int c = 0; c < 3000; c++) begin
      req = N'($urandom);
      if (($urandom % 16) == 0) mode = 2'($urandom);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule